// File: doc/BRIEF.md
# Ramp-Timed Limit Checker With Interlock

This block raises per-channel over-limit and under-limit warnings for a monitor that digitises several analog inputs against one shared staircase ramp. It never compares magnitudes. For each channel it watches for the instant the live ramp step count equals a downloaded limit. It then looks at whether that channel's converter has already reported valid data in the current ramp. If the upper limit is reached while the input is still above the ramp, the input is too high. If the lower limit is reached after the input has been captured, the input is too low.

Warnings are sticky status bits that software clears by register writes. A per-channel mask keeps a channel's warnings away from every action output. The unmasked warnings feed three registered action outputs, each with its own enable bit: a warning flag for the data stream, a hybrid clock disable and a front-end regulator disable.

Top module: `ramp_limit_chk`

## Requirements
- R1: After reset all warning bits, the data-stream flag and both disable outputs are 0, and all limits, the mask and the control bits are 0.
- R2: A channel's limits are compared for equality against step count bits [9:1], the upper nine of the ten-bit count. No comparison takes effect before the first ramp-start pulse after reset.
- R3: If the upper limit equals the compared count bits in a cycle where the channel has not yet had valid data in this ramp, the channel's high warning bit is set on the next clock edge.
- R4: If the lower limit equals the compared count bits in a cycle where the channel has had valid data in this ramp, the channel's low warning bit is set on the next clock edge. A valid pulse counts from its own cycle onward.
- R5: The remembered valid state of every channel is cleared by the ramp-start pulse, so a valid pulse in an earlier ramp does not qualify matches in the next one. A valid pulse in the ramp-start cycle itself does count.
- R6: Warning bits are sticky. Writing 1s to address 2 clears the chosen high bits and writing 1s to address 3 clears the chosen low bits, bit c meaning channel c. A set and a clear in the same cycle leave the bit set.
- R7: Address 1 holds the mask. Bit c = 1 removes channel c from all three action outputs, while its warning bits still show on the status outputs.
- R8: Address 0 bit 0 enables the data-stream flag. The flag is 1 exactly one clock after any unmasked warning bit is 1 while the enable is set.
- R9: Address 0 bit 1 enables the clock disable and bit 2 enables the regulator disable. Each output is the registered OR of the unmasked warnings gated only by its own bit.
- R10: Address 4+2c holds the upper limit of channel c and address 5+2c its lower limit. Each is nine bits and is written from the low write-data bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ramp_start_i | input | 1 | One-cycle pulse at the first step of a ramp |
| step_cnt_i | input | 10 | Live ramp step count |
| valid_i | input | 7 | Per-channel valid-data pulse from the converters |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 5 | Register write address |
| cfg_wdata_i | input | 9 | Register write data |
| warn_hi_o | output | 7 | Sticky high warning per channel |
| warn_lo_o | output | 7 | Sticky low warning per channel |
| flag_o | output | 1 | Warning flag for the data stream |
| clk_dis_o | output | 1 | Hybrid clock disable |
| reg_dis_o | output | 1 | Front-end regulator disable |

## Verification
The hardest case to reach from the ports is a warning set and a clear write landing in the same cycle. It needs a limit match timed exactly against a register write. The bench steps the ramp count by hand, so one limit matches on two known cycles, and issues the clear on both of them. The bench then checks that the bit survives, and that a clear issued one step later removes it. The timing decisions are swept over several full ramps. Each ramp uses arithmetically varied limits, valid positions, missing valid pulses, masks and enables, and the expected outcome of every case is derived from where the limit falls relative to the valid step.

// File: rtl/lc_pkg.sv
package lc_pkg;
  localparam int unsigned ADDR_CTRL   = 0;
  localparam int unsigned ADDR_MASK   = 1;
  localparam int unsigned ADDR_CLR_HI = 2;
  localparam int unsigned ADDR_CLR_LO = 3;
  localparam int unsigned ADDR_LIM0   = 4;
  localparam int unsigned CTRL_FLAG   = 0;
  localparam int unsigned CTRL_CLK    = 1;
  localparam int unsigned CTRL_REG    = 2;
  localparam int unsigned CTRL_W      = 3;
endpackage

// File: rtl/lc_cfg_regs.sv
module lc_cfg_regs
  import lc_pkg::*;
#(
  parameter int unsigned N_CH   = 7,
  parameter int unsigned LIM_W  = 9,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 9
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [N_CH-1:0][LIM_W-1:0] hi_lim_o,
  output logic [N_CH-1:0][LIM_W-1:0] lo_lim_o,
  output logic [N_CH-1:0]            mask_o,
  output logic [CTRL_W-1:0]          ctrl_o,
  output logic [N_CH-1:0]            clr_hi_o,
  output logic [N_CH-1:0]            clr_lo_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o <= '0;
      ctrl_o <= '0;
    end else if (we_i) begin
      if (addr_i == ADDR_W'(ADDR_MASK)) mask_o <= wdata_i[N_CH-1:0];
      if (addr_i == ADDR_W'(ADDR_CTRL)) ctrl_o <= wdata_i[CTRL_W-1:0];
    end
  end

  // clear strobes are single-cycle, applied in the channels
  assign clr_hi_o = (we_i && addr_i == ADDR_W'(ADDR_CLR_HI)) ? wdata_i[N_CH-1:0] : '0;
  assign clr_lo_o = (we_i && addr_i == ADDR_W'(ADDR_CLR_LO)) ? wdata_i[N_CH-1:0] : '0;

  for (genvar c = 0; c < N_CH; c++) begin : g_lim
    localparam int unsigned HI_ADDR = ADDR_LIM0 + 2 * c;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hi_lim_o[c] <= '0;
        lo_lim_o[c] <= '0;
      end else if (we_i) begin
        if (addr_i == ADDR_W'(HI_ADDR))     hi_lim_o[c] <= wdata_i[LIM_W-1:0];
        if (addr_i == ADDR_W'(HI_ADDR + 1)) lo_lim_o[c] <= wdata_i[LIM_W-1:0];
      end
    end
  end

  p_mask_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(ADDR_MASK)) |=> (mask_o == $past(wdata_i[N_CH-1:0])));
endmodule

// File: rtl/lc_chan.sv
module lc_chan #(
  parameter int unsigned LIM_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             ramp_start_i,
  input  logic             valid_i,
  input  logic [LIM_W-1:0] cnt_i,
  input  logic [LIM_W-1:0] hi_lim_i,
  input  logic [LIM_W-1:0] lo_lim_i,
  input  logic             clr_hi_i,
  input  logic             clr_lo_i,
  output logic             warn_hi_o,
  output logic             warn_lo_o
);
  logic valid_q, seen, set_hi, set_lo;

  // ramp start drops the previous ramp's qualification
  assign seen   = valid_i | (valid_q & ~ramp_start_i);
  assign set_hi = active_i && (cnt_i == hi_lim_i) && !seen;
  assign set_lo = active_i && (cnt_i == lo_lim_i) && seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q   <= 1'b0;
      warn_hi_o <= 1'b0;
      warn_lo_o <= 1'b0;
    end else begin
      valid_q   <= seen;
      warn_hi_o <= set_hi | (warn_hi_o & ~clr_hi_i);
      warn_lo_o <= set_lo | (warn_lo_o & ~clr_lo_i);
    end
  end

  p_hi_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && cnt_i == hi_lim_i && !valid_i && (ramp_start_i || !valid_q)) |=> warn_hi_o);
  p_lo_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && cnt_i == lo_lim_i && valid_i) |=> warn_lo_o);
  p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warn_hi_o && !clr_hi_i) |=> warn_hi_o);
  p_no_stale_valid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ramp_start_i && !valid_i) |=> !valid_q);
endmodule

// File: rtl/lc_interlock.sv
module lc_interlock
  import lc_pkg::*;
#(
  parameter int unsigned N_CH = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CH-1:0]   warn_hi_i,
  input  logic [N_CH-1:0]   warn_lo_i,
  input  logic [N_CH-1:0]   mask_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic              flag_o,
  output logic              clk_dis_o,
  output logic              reg_dis_o
);
  logic any_warn;
  assign any_warn = |((warn_hi_i | warn_lo_i) & ~mask_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o    <= 1'b0;
      clk_dis_o <= 1'b0;
      reg_dis_o <= 1'b0;
    end else begin
      flag_o    <= any_warn & ctrl_i[CTRL_FLAG];
      clk_dis_o <= any_warn & ctrl_i[CTRL_CLK];
      reg_dis_o <= any_warn & ctrl_i[CTRL_REG];
    end
  end

  p_mask_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((warn_hi_i | warn_lo_i) & ~mask_i) == '0) |=> !(flag_o || clk_dis_o || reg_dis_o));
  p_flag_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i[CTRL_FLAG] |=> !flag_o);
  p_clk_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i[CTRL_CLK] |=> !clk_dis_o);
  p_reg_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i[CTRL_REG] |=> !reg_dis_o);
endmodule

// File: rtl/ramp_limit_chk.sv
module ramp_limit_chk
  import lc_pkg::*;
#(
  parameter int unsigned N_CH   = 7,
  parameter int unsigned CNT_W  = 10,
  parameter int unsigned LIM_W  = 9,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ramp_start_i,
  input  logic [CNT_W-1:0]  step_cnt_i,
  input  logic [N_CH-1:0]   valid_i,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic [N_CH-1:0]   warn_hi_o,
  output logic [N_CH-1:0]   warn_lo_o,
  output logic              flag_o,
  output logic              clk_dis_o,
  output logic              reg_dis_o
);
  localparam int unsigned CMP_LSB = CNT_W - LIM_W;

  logic [N_CH-1:0][LIM_W-1:0] hi_lim, lo_lim;
  logic [N_CH-1:0]            mask, clr_hi, clr_lo;
  logic [CTRL_W-1:0]          ctrl;
  logic                       armed_q, active;
  logic [LIM_W-1:0]           cnt_cmp;

  assign cnt_cmp = step_cnt_i[CNT_W-1:CMP_LSB];
  assign active  = armed_q | ramp_start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           armed_q <= 1'b0;
    else if (ramp_start_i) armed_q <= 1'b1;
  end

  lc_cfg_regs #(
    .N_CH(N_CH), .LIM_W(LIM_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .hi_lim_o(hi_lim), .lo_lim_o(lo_lim), .mask_o(mask), .ctrl_o(ctrl),
    .clr_hi_o(clr_hi), .clr_lo_o(clr_lo)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    lc_chan #(.LIM_W(LIM_W)) u_chan (
      .clk_i, .rst_ni,
      .active_i(active), .ramp_start_i(ramp_start_i), .valid_i(valid_i[c]),
      .cnt_i(cnt_cmp), .hi_lim_i(hi_lim[c]), .lo_lim_i(lo_lim[c]),
      .clr_hi_i(clr_hi[c]), .clr_lo_i(clr_lo[c]),
      .warn_hi_o(warn_hi_o[c]), .warn_lo_o(warn_lo_o[c])
    );
  end

  lc_interlock #(.N_CH(N_CH)) u_ilk (
    .clk_i, .rst_ni,
    .warn_hi_i(warn_hi_o), .warn_lo_i(warn_lo_o), .mask_i(mask), .ctrl_i(ctrl),
    .flag_o, .clk_dis_o, .reg_dis_o
  );

  p_unarmed_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_q && !ramp_start_i && warn_hi_o == '0 && warn_lo_o == '0 && !cfg_we_i)
      |=> (warn_hi_o == '0 && warn_lo_o == '0));
endmodule

// File: tb/ramp_limit_chk_bench.sv
module ramp_limit_chk_bench;
  localparam int N = 7;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ramp_start = 1'b0;
  logic [9:0] cnt = 10'd1023;
  logic [N-1:0] valid = '0;
  logic we = 1'b0;
  logic [4:0] addr = '0;
  logic [8:0] wdata = '0;
  logic [N-1:0] whi, wlo;
  logic flag, cdis, rdis;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ramp_limit_chk u_ramp_limit_chk (
    .clk_i(clk), .rst_ni(rst_n), .ramp_start_i(ramp_start), .step_cnt_i(cnt),
    .valid_i(valid), .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
    .warn_hi_o(whi), .warn_lo_o(wlo), .flag_o(flag), .clk_dis_o(cdis), .reg_dis_o(rdis)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); we = 1'b1; addr = 5'(a); wdata = 9'(d);
    @(negedge clk); we = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int vpos[N], lh[N], ll[N];
    int ehi, elo, mask, en, anyw;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 / R2: idle, count at 0 matches reset limits but nothing is armed yet
    cnt = 10'd0;
    repeat (4) @(negedge clk);
    chk("R1 R2 warn_hi reset", int'(whi), 0);
    chk("R1 warn_lo reset", int'(wlo), 0);
    chk("R1 outputs reset", int'({flag, cdis, rdis}), 0);
    cnt = 10'd1023;
    @(negedge clk);

    for (int r = 0; r < 8; r++) begin
      mask = (r * 37) % 128;
      en = r % 8;
      wr(0, en);
      wr(1, mask);
      for (int c = 0; c < N; c++) begin
        vpos[c] = (r * 211 + c * 137 + 5) % 1100;
        lh[c] = (r * 53 + c * 71 + 3) % 511;
        ll[c] = (r * 89 + c * 29 + 7) % 511;
        wr(4 + 2 * c, lh[c]);
        wr(5 + 2 * c, ll[c]);
      end
      wr(2, 127);
      wr(3, 127);
      for (int s = 0; s < 1024; s++) begin
        @(negedge clk);
        ramp_start = (s == 0);
        cnt = 10'(s);
        for (int c = 0; c < N; c++) valid[c] = (vpos[c] == s);
      end
      @(negedge clk);
      ramp_start = 1'b0; valid = '0; cnt = 10'd1023;
      repeat (3) @(negedge clk);
      ehi = 0; elo = 0;
      for (int c = 0; c < N; c++) begin
        int h, l;
        h = (2 * lh[c] < vpos[c]) ? 1 : 0;
        l = (vpos[c] < 1024 && 2 * ll[c] + 1 >= vpos[c]) ? 1 : 0;
        ehi |= h << c; elo |= l << c;
        chk("R3 R5 high warning", int'(whi[c]), h);
        chk("R4 R5 low warning", int'(wlo[c]), l);
      end
      anyw = (((ehi | elo) & ~mask & 127) != 0) ? 1 : 0;
      chk("R7 R8 flag", int'(flag), anyw & en);
      chk("R9 clock disable", int'(cdis), anyw & (en >> 1) & 1);
      chk("R9 regulator disable", int'(rdis), anyw & (en >> 2) & 1);
    end

    // R7: full mask silences actions but status stays
    wr(0, 7);
    wr(1, 127);
    repeat (2) @(negedge clk);
    chk("R7 masked actions", int'({flag, cdis, rdis}), 0);
    chk("R7 status kept", int'((whi | wlo) != 0), 1);
    wr(1, 0);
    repeat (2) @(negedge clk);
    chk("R9 R10 unmasked actions", int'({flag, cdis, rdis}), 7);
    // R6: clearing
    wr(2, 127);
    wr(3, 127);
    @(negedge clk);
    chk("R6 clear hi", int'(whi), 0);
    chk("R6 clear lo", int'(wlo), 0);
    repeat (2) @(negedge clk);
    chk("R8 flag drops", int'(flag), 0);

    // R6: set wins over clear; channel 0 upper limit 5 matches steps 10,11
    wr(4, 5);
    @(negedge clk); ramp_start = 1'b1; cnt = 10'd0;
    @(negedge clk); ramp_start = 1'b0; cnt = 10'd2;
    @(negedge clk); cnt = 10'd10; we = 1'b1; addr = 5'd2; wdata = 9'd127;
    @(negedge clk); cnt = 10'd11;
    @(negedge clk); cnt = 10'd12; we = 1'b0;
    chk("R6 set wins", int'(whi[0]), 1);
    we = 1'b1;
    @(negedge clk); we = 1'b0; cnt = 10'd1023;
    chk("R6 clear alone", int'(whi[0]), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule